// File: doc/BRIEF.md
# Record Control Registers with Shadow Staging

This block holds the control word and the 32-bit record-length counter of a record-oriented engine. Each of them has a shadow ("prearm") copy, so software can program the next record while the current one is still in flight. A write made while the engine is busy lands only in the shadow. The live copy takes the shadow value when the `eor` pulse marks the end of the record.

The length counter is loaded one byte at a time. A write to one of the three low bytes only stages that byte. The staged value replaces the count at the next end of record. A write to the top byte loads the whole four-byte value into the counter at once. Without a pending reload, each end of record decrements the counter by one. A one-cycle flag marks the end of record that brings the count from one to zero, which signals the end of the transfer. Shadow staging is always on and has no bypass.

Top module: `rec_prearm_regs`

## Requirements
- R1: After reset, `ctrl_active` is 0, `count` is 0 and `count_zero` is 0.
- R2: A control write (`wr_en`=1, `wr_len`=0) with `busy`=0 shows on `ctrl_active` in the next cycle.
- R3: A control write with `busy`=1 and `eor`=0 leaves `ctrl_active` unchanged. The written value is applied at the next `eor`.
- R4: If the control shadow is written several times during one record, the value applied at `eor` is the last one written.
- R5: A length write to byte 0, 1 or 2 (`wr_len`=1, `wr_byte` 0..2, where byte 0 holds bits 7:0) does not change `count` in the next cycle.
- R6: A length write to byte 3 (bits 31:24) loads `count` in the next cycle with the written top byte and the three staged low bytes.
- R7: At `eor`, if a low byte was written since the last load, `count` is reloaded from the staged four-byte value instead of being decremented.
- R8: At `eor` with no pending reload, `count` decrements by one. At zero it stays at zero.
- R9: `count_zero` is high for exactly the one cycle after an `eor` that takes `count` from 1 to 0.
- R10: A top-byte write in the same cycle as `eor` wins. `count` takes the loaded value, with no decrement and no zero pulse.
- R11: A control write in the same cycle as `eor` is applied at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_len | input | 1 | 0 selects the control register, 1 selects the length register |
| wr_byte | input | 2 | Length byte select, 3 is the most significant byte |
| wr_data | input | 8 | Write data |
| busy | input | 1 | A record is being processed |
| eor | input | 1 | End-of-record pulse |
| ctrl_active | output | 8 | Control value in force |
| count | output | 32 | Record-length counter |
| count_zero | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bench targets the collisions between writes and `eor`:
- **Top-byte load against `eor`.** A design that lets the decrement win there would show the loaded value minus one.
- **Control write against `eor`.** A design that drops the write would apply the stale shadow.
- **Low-byte staging.** This is tested both alone and followed by an `eor`. A design that loads low bytes immediately, or forgets the pending reload, shows a wrong count one cycle early or late.
- **Zero flag.** It is checked at the 1-to-0 step and again at zero. A flag that stays high, or fires when the counter sits at zero, is caught.

// File: rtl/rec_prearm_regs.sv
module rec_prearm_regs #(
  parameter int CTRL_W    = 8,
  parameter int LEN_BYTES = 4,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_len,
  input  logic [$clog2(LEN_BYTES)-1:0] wr_byte,
  input  logic [7:0]                  wr_data,
  input  logic                        busy,
  input  logic                        eor,
  output logic [CTRL_W-1:0]           ctrl_active,
  output logic [8*LEN_BYTES-1:0]      count,
  output logic                        count_zero
);
  localparam int LEN_W  = 8 * LEN_BYTES;
  localparam int BSEL_W = $clog2(LEN_BYTES);
  localparam logic [BSEL_W-1:0] TOP = BSEL_W'(LEN_BYTES - 1);

  logic [CTRL_W-1:0] ctrl_shadow;
  logic [LEN_W-1:0]  stage, stage_nxt;
  logic              pend;

  wire ctrl_wr = wr_en & ~wr_len;
  wire top_wr  = wr_en & wr_len & (wr_byte == TOP);
  wire low_wr  = wr_en & wr_len & (wr_byte != TOP);
  wire [CTRL_W-1:0] ctrl_wd = wr_data[CTRL_W-1:0];

  always_comb begin
    stage_nxt = stage;
    for (int b = 0; b < LEN_BYTES; b++)
      if (wr_en && wr_len && wr_byte == BSEL_W'(b))
        stage_nxt[8*b +: 8] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_shadow <= CTRL_RST;
      ctrl_active <= CTRL_RST;
      stage       <= '0;
      count       <= '0;
      pend        <= 1'b0;
      count_zero  <= 1'b0;
    end else begin
      stage      <= stage_nxt;
      count_zero <= 1'b0;
      if (ctrl_wr) ctrl_shadow <= ctrl_wd;
      if (ctrl_wr && (!busy || eor)) ctrl_active <= ctrl_wd;
      else if (eor)                  ctrl_active <= ctrl_shadow;
      if (top_wr) begin
        count <= stage_nxt;
        pend  <= 1'b0;
      end else if (eor) begin
        pend <= 1'b0;
        if (pend || low_wr) count <= stage_nxt;
        else if (count != '0) begin
          count      <= count - LEN_W'(1);
          count_zero <= (count == LEN_W'(1));
        end
      end else if (low_wr) begin
        pend <= 1'b1;
      end
    end
  end

  AST_IDLE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !busy |=> ctrl_active == $past(ctrl_wd));                     // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !eor |=> $stable(ctrl_active));                                  // R3
  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr && !eor |=> $stable(count));                                      // R5
  AST_TOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    top_wr |=> count[LEN_W-1 -: 8] == $past(wr_data));                       // R6
  AST_ZERO_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    count_zero |-> count == '0);                                             // R9
  AST_ZERO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    count_zero |=> !count_zero);                                             // R9
  AST_TOP_NO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    top_wr |=> !count_zero);                                                 // R10
endmodule

// File: tb/rec_prearm_regs_tb_top.sv
module rec_prearm_regs_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_len = 0, busy = 0, eor = 0;
  logic [1:0] wr_byte = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_active;
  logic [31:0] count;
  logic count_zero;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rec_prearm_regs dut_i (.clk, .rst_n, .wr_en, .wr_len, .wr_byte, .wr_data,
    .busy, .eor, .ctrl_active, .count, .count_zero);

  logic [7:0] m_ctrl = 0, m_sh = 0;
  logic [7:0] m_stage [4] = '{0, 0, 0, 0};
  logic [31:0] m_cnt = 0;
  bit m_pend = 0, m_zero = 0;

  function automatic logic [31:0] stage_word();
    return {m_stage[3], m_stage[2], m_stage[1], m_stage[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sh = 0; m_cnt = 0; m_pend = 0; m_zero = 0;
      for (int i = 0; i < 4; i++) m_stage[i] = 0;
    end else begin
      bit lw, tw;
      lw = wr_en && wr_len && wr_byte != 3;
      tw = wr_en && wr_len && wr_byte == 3;
      m_zero = 0;
      if (wr_en && wr_len) m_stage[wr_byte] = wr_data;
      if (wr_en && !wr_len) begin
        m_sh = wr_data;
        if (!busy || eor) m_ctrl = wr_data;
        else if (eor) m_ctrl = m_sh;
      end else if (eor) m_ctrl = m_sh;
      if (tw) begin m_cnt = stage_word(); m_pend = 0; end
      else if (eor) begin
        if (m_pend || lw) m_cnt = stage_word();
        else if (m_cnt != 0) begin m_zero = (m_cnt == 1); m_cnt = m_cnt - 1; end
        m_pend = 0;
      end else if (lw) m_pend = 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("MODEL ctrl", 32'(ctrl_active), 32'(m_ctrl));
    chk("MODEL count", count, m_cnt);
    chk("MODEL zero", 32'(count_zero), 32'(m_zero));
  end

  task automatic cyc(bit we, bit wl, logic [1:0] wb, logic [7:0] wd, bit e);
    wr_en = we; wr_len = wl; wr_byte = wb; wr_data = wd; eor = e;
    @(negedge clk);
    wr_en = 0; eor = 0;
  endtask

  initial begin
    #400000 $display("FAIL watchdog: actual hung expected done");
    errors++; checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl", 32'(ctrl_active), 0);
    chk("R1 count", count, 0);
    chk("R1 zero", 32'(count_zero), 0);
    cyc(1, 0, 0, 8'h5A, 0);
    chk("R2", 32'(ctrl_active), 32'h5A);
    busy = 1;
    cyc(1, 0, 0, 8'h11, 0);
    cyc(1, 0, 0, 8'h22, 0);
    chk("R3", 32'(ctrl_active), 32'h5A);
    cyc(0, 0, 0, 0, 1);
    chk("R4", 32'(ctrl_active), 32'h22);
    cyc(1, 1, 0, 8'h03, 0);
    cyc(1, 1, 1, 8'h00, 0);
    cyc(1, 1, 2, 8'h00, 0);
    chk("R5", count, 0);
    cyc(1, 1, 3, 8'h00, 0);
    chk("R6", count, 3);
    cyc(0, 0, 0, 0, 1);
    chk("R8 dec", count, 2);
    cyc(0, 0, 0, 0, 1);
    chk("R8 dec", count, 1);
    chk("R9 no early", 32'(count_zero), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R9 count", count, 0);
    chk("R9 pulse", 32'(count_zero), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R9 one cycle", 32'(count_zero), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R8 hold zero", count, 0);
    chk("R9 none at zero", 32'(count_zero), 0);
    cyc(1, 1, 0, 8'h07, 0);
    chk("R5 stage only", count, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R7", count, 7);
    cyc(0, 0, 0, 0, 1);
    chk("R8 after reload", count, 6);
    cyc(1, 1, 3, 8'h01, 1);
    chk("R10 load", count, 32'h0100_0007);
    chk("R10 no zero", 32'(count_zero), 0);
    cyc(1, 0, 0, 8'h77, 1);
    chk("R11", 32'(ctrl_active), 32'h77);
    busy = 0;
    cyc(1, 1, 2, 8'hAB, 0);
    cyc(1, 1, 3, 8'h00, 0);
    chk("R6 merge", count, 32'h00AB_0007);
    for (int i = 0; i < 200; i++)
      cyc(1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule